// File: doc/BRIEF.md
# Debug Scan Data Register

This block is a user-defined data register that sits behind a boundary-scan primitive. It lets a host observe a processor and stop or single-step it. The scan side runs on the gated data clock that the primitive supplies. While its select line is high, the block performs one of three actions. A capture action takes a snapshot of a parallel status word from the system. A shift action moves one bit per clock from `tdi` toward `tdo`. An update action freezes the shifted word.

The frozen word is carried into the system clock domain with a toggle-and-synchroniser handshake. On the system side it appears on `par_out`, together with a single-cycle `upd_pulse`. With the default 138-bit width, the top two bits of that word drive the processor's halt request and step request lines. The register length is a parameter. A one-bit instance serves only as a chain filler. A tap reset clears the shift stage. It leaves the published system word alone, so a host may reset the test logic before every access without releasing a halt.

Top module: `dbg_scan_reg`

## Requirements
- R1: System reset `rst` (synchronous, active high) drives `par_out` to all zeros and `upd_pulse`, `halt_req` and `step_req` low. Leaving reset does not republish the last updated word.
- R2: A capture action loads `par_in` into the shift stage. A capture action is `tap_sel` and `tap_capture` high at a rising `tck` edge. The debug word layout is: bit 137 halt, bit 136 step, bits 135:104 program counter, bits 103:96 opcode, bits 95:64 top-of-stack, bits 63:32 second stack cell, bits 31:0 return-stack top.
- R3: A shift action moves the stage one bit toward the LSB and puts `tdi` into the MSB. A shift action is `tap_sel` and `tap_shift` high, with `tap_capture` low. While `tap_sel` is high, `tdo` shows the current LSB. A host therefore receives bits 31:0 first and bit 137 last.
- R4: A full W-bit shift followed by an update action makes `par_out` equal the shifted word within 6 system clocks. An update action is `tap_sel` and `tap_update` high, with capture and shift low. Updates are published in the order they were issued.
- R5: Each update produces exactly one `upd_pulse` of one system clock. `par_out` changes only in a cycle where `upd_pulse` is high.
- R6: While `tap_sel` is low, the capture, shift and update strobes have no effect, and `tdo` is 0.
- R7: When capture and shift are both high at the same `tck` edge, capture takes effect and no shift happens.
- R8: `tap_reset` clears the shift stage to zeros. It does not change `par_out` and does not produce `upd_pulse`.
- R9: At the default width, `halt_req` equals `par_out` bit 137 and `step_req` equals `par_out` bit 136.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| tck | input | 1 | Gated data clock from the scan primitive |
| tap_reset | input | 1 | Test-logic reset, synchronous to `tck` |
| tap_sel | input | 1 | This register's instruction is selected |
| tap_capture | input | 1 | Capture strobe |
| tap_shift | input | 1 | Shift strobe |
| tap_update | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (LSB of stage) |
| par_in | input | W | Parallel status word from the system |
| par_out | output | W | Published word, system clock domain |
| upd_pulse | output | 1 | One-cycle marker of a new published word |
| halt_req | output | 1 | Processor halt request |
| step_req | output | 1 | Processor single-step request |

## Verification
Capture and shift can both be asserted at the same `tck` edge. The bench provokes this by raising both strobes for one edge, with `tdi` high, while a known status word sits on `par_in`. It then shifts the whole stage out. The result is judged correct only if the word read on `tdo` equals the status word bit for bit; a shift winning would displace every bit by one. A second overlap is a system reset arriving while an earlier word is still held on the scan side. That word must not reappear on `par_out` once reset is released.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;

    localparam int PC_W   = 32;
    localparam int OP_W   = 8;
    localparam int CELL_W = 32;
    localparam int DBG_W  = 2 + PC_W + OP_W + 3 * CELL_W;

    // Field view of the debug word, MSB first.
    typedef struct packed {
        logic              halt;
        logic              step;
        logic [PC_W-1:0]   pc;
        logic [OP_W-1:0]   opcode;
        logic [CELL_W-1:0] tos;
        logic [CELL_W-1:0] nos;
        logic [CELL_W-1:0] rtos;
    } dbg_word_t;

    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_CAPTURE = 2'd1,
        ACT_SHIFT   = 2'd2,
        ACT_UPDATE  = 2'd3
    } scan_act_e;

    // Priority: capture over shift over update; nothing when deselected.
    function automatic scan_act_e decode_act(input logic sel, input logic cap,
                                             input logic shf, input logic upd);
        if (!sel)     return ACT_IDLE;
        else if (cap) return ACT_CAPTURE;
        else if (shf) return ACT_SHIFT;
        else if (upd) return ACT_UPDATE;
        else          return ACT_IDLE;
    endfunction

endpackage

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain
    import dbg_scan_pkg::*;
#(
    parameter int W = DBG_W
) (
    input  logic         tck,
    input  logic         tap_reset,
    input  logic         tap_sel,
    input  logic         tap_capture,
    input  logic         tap_shift,
    input  logic         tap_update,
    input  logic         tdi,
    input  logic [W-1:0] par_in,
    output logic         tdo,
    output logic [W-1:0] hold_o,
    output logic         tog_o
);

    scan_act_e    act;
    logic [W-1:0] sr_q;
    logic [W-1:0] sr_shifted;
    // Hold stage and toggle are not touched by tap_reset; power-up value only.
    logic [W-1:0] hold_q = '0;
    logic         tog_q  = 1'b0;

    assign act = decode_act(tap_sel, tap_capture, tap_shift, tap_update);

    generate
        if (W == 1) begin : g_one
            assign sr_shifted = tdi;
        end else begin : g_many
            assign sr_shifted = {tdi, sr_q[W-1:1]};
        end
    endgenerate

    always_ff @(posedge tck) begin
        if (tap_reset) begin
            sr_q <= '0;
        end else begin
            case (act)
                ACT_CAPTURE: sr_q <= par_in;
                ACT_SHIFT:   sr_q <= sr_shifted;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge tck) begin
        if (!tap_reset && act == ACT_UPDATE) begin
            hold_q <= sr_q;
            tog_q  <= ~tog_q;
        end
    end

    assign tdo    = tap_sel ? sr_q[0] : 1'b0;
    assign hold_o = hold_q;
    assign tog_o  = tog_q;

    // R2 and R7: capture wins even when shift is also high.
    p_capture_load_r2: assert property (@(posedge tck) disable iff (tap_reset)
        (tap_sel && tap_capture) |=> (sr_q == $past(par_in)));

    p_shift_msb_r3: assert property (@(posedge tck) disable iff (tap_reset)
        (tap_sel && tap_shift && !tap_capture) |=> (sr_q[W-1] == $past(tdi)));

    p_hold_only_on_update_r4: assert property (@(posedge tck) disable iff (tap_reset)
        !(tap_sel && tap_update) |=> ($stable(tog_q) && $stable(hold_q)));

endmodule

// File: rtl/dbg_publish_sync.sv
module dbg_publish_sync #(
    parameter int W      = 138,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hold_i,
    input  logic         tog_i,
    output logic [W-1:0] par_out,
    output logic         upd_pulse
);

    localparam int LAST = STAGES;

    // sync_q[0..STAGES-1] synchronise, sync_q[LAST] is the last seen level.
    logic [STAGES:0] sync_q = '0;
    logic            fresh;

    always_ff @(posedge clk) begin
        sync_q <= {sync_q[STAGES-1:0], tog_i};
    end

    assign fresh = sync_q[LAST] ^ sync_q[LAST-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            par_out   <= '0;
            upd_pulse <= 1'b0;
        end else begin
            upd_pulse <= fresh;
            if (fresh) begin
                par_out <= hold_i;
            end
        end
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (par_out == '0 && !upd_pulse));

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |=> !upd_pulse);

    p_out_stable_r5: assert property (@(posedge clk) disable iff (rst)
        !upd_pulse |-> $stable(par_out));

endmodule

// File: rtl/dbg_scan_reg.sv
module dbg_scan_reg
    import dbg_scan_pkg::*;
#(
    parameter int W           = DBG_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tck,
    input  logic         tap_reset,
    input  logic         tap_sel,
    input  logic         tap_capture,
    input  logic         tap_shift,
    input  logic         tap_update,
    input  logic         tdi,
    output logic         tdo,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] par_out,
    output logic         upd_pulse,
    output logic         halt_req,
    output logic         step_req
);

    logic [W-1:0] hold_w;
    logic         tog_w;

    dbg_scan_chain #(.W(W)) u_chain (
        .tck         (tck),
        .tap_reset   (tap_reset),
        .tap_sel     (tap_sel),
        .tap_capture (tap_capture),
        .tap_shift   (tap_shift),
        .tap_update  (tap_update),
        .tdi         (tdi),
        .par_in      (par_in),
        .tdo         (tdo),
        .hold_o      (hold_w),
        .tog_o       (tog_w)
    );

    dbg_publish_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .hold_i    (hold_w),
        .tog_i     (tog_w),
        .par_out   (par_out),
        .upd_pulse (upd_pulse)
    );

    generate
        if (W == DBG_W) begin : g_dbg_view
            dbg_word_t view;
            assign view     = par_out;
            assign halt_req = view.halt;
            assign step_req = view.step;
        end else begin : g_filler
            assign halt_req = 1'b0;
            assign step_req = 1'b0;
        end
    endgenerate

endmodule

// File: tb/dbg_scan_reg_tb.sv
module dbg_scan_reg_tb;
    import dbg_scan_pkg::*;

    localparam int W = DBG_W;

    logic         clk = 1'b0;
    logic         tck = 1'b0;
    logic         rst;
    logic         tap_reset, tap_sel, tap_capture, tap_shift, tap_update, tdi;
    logic         tdo;
    logic [W-1:0] par_in;
    logic [W-1:0] par_out;
    logic         upd_pulse, halt_req, step_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [W-1:0] exp_q[$];
    logic [W-1:0] last_out = '0;
    logic         prev_pulse = 1'b0;

    always #10 clk = ~clk;
    always #33 tck = ~tck;

    dbg_scan_reg u_dut (
        .clk(clk), .rst(rst), .tck(tck), .tap_reset(tap_reset),
        .tap_sel(tap_sel), .tap_capture(tap_capture), .tap_shift(tap_shift),
        .tap_update(tap_update), .tdi(tdi), .tdo(tdo), .par_in(par_in),
        .par_out(par_out), .upd_pulse(upd_pulse), .halt_req(halt_req),
        .step_req(step_req)
    );

    function automatic logic [W-1:0] mk(input logic h, input logic s,
        input logic [31:0] pc, input logic [7:0] op, input logic [31:0] t,
        input logic [31:0] n, input logic [31:0] r);
        logic [W-1:0] v;
        v = '0;
        v[137] = h;  v[136] = s;  v[135:104] = pc;  v[103:96] = op;
        v[95:64] = t; v[63:32] = n; v[31:0] = r;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Scoreboard monitor: pops one expected word per update pulse.
    always @(negedge clk) begin
        if (rst) begin
            last_out   <= '0;
            prev_pulse <= 1'b0;
        end else begin
            if (upd_pulse) begin
                chk(!prev_pulse, "R5", "pulse wider than one cycle", W'(prev_pulse), '0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "pulse with no update pending", par_out, last_out);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    chk(par_out == e, "R4", "published word", par_out, e);
                    chk({halt_req, step_req} == {e[137], e[136]}, "R9",
                        "halt/step lines", W'({halt_req, step_req}), W'({e[137], e[136]}));
                end
            end else begin
                chk(par_out == last_out, "R5", "output changed without pulse", par_out, last_out);
            end
            last_out   <= par_out;
            prev_pulse <= upd_pulse;
        end
    end

    // cap_mode: 0 none, 1 capture, 2 capture and shift on the same edge.
    task automatic scan(input logic [W-1:0] din, input int cap_mode,
                        input bit do_upd, output logic [W-1:0] dout);
        @(negedge tck);
        tap_sel = 1'b1;
        if (cap_mode == 1) begin
            tap_capture = 1'b1;
            @(negedge tck);
            tap_capture = 1'b0;
        end else if (cap_mode == 2) begin
            tap_capture = 1'b1;
            tap_shift   = 1'b1;
            tdi         = 1'b1;
            @(negedge tck);
            tap_capture = 1'b0;
        end
        for (int i = 0; i < W; i++) begin
            tap_shift = 1'b1;
            tdi       = din[i];
            #1 dout[i] = tdo;
            @(negedge tck);
        end
        tap_shift = 1'b0;
        if (do_upd) begin
            tap_update = 1'b1;
            exp_q.push_back(din);
            @(negedge tck);
            tap_update = 1'b0;
        end
        tap_sel = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 200; k++) begin
            if (exp_q.size() == 0) break;
            @(negedge clk);
        end
        chk(exp_q.size() == 0, "R4", "update not published in time",
            W'(exp_q.size()), '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d, w1, w2, w3, w4, w5, w6, w7;
        rst = 1'b1; tap_reset = 1'b1; tap_sel = 1'b0; tap_capture = 1'b0;
        tap_shift = 1'b0; tap_update = 1'b0; tdi = 1'b0; par_in = '0;
        repeat (3) @(negedge tck);
        tap_reset = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(par_out == '0, "R1", "par_out after reset", par_out, '0);
        chk({upd_pulse, halt_req, step_req} == 3'b000, "R1", "pulse/halt/step after reset",
            W'({upd_pulse, halt_req, step_req}), '0);
        chk(tdo == 1'b0, "R6", "tdo while deselected", W'(tdo), '0);
        @(negedge clk) rst = 1'b0;

        w1 = mk(1'b1, 1'b0, 32'h0000_1234, 8'h0d, 32'hAAAA_0001, 32'h5555_0002, 32'hC3C3_0003);
        w2 = mk(1'b1, 1'b1, 32'h8000_0040, 8'h18, 32'h1111_2222, 32'h3333_4444, 32'h0F0F_F0F0);
        w3 = mk(1'b0, 1'b1, 32'hDEAD_BEEF, 8'h01, 32'h0000_0001, 32'h8000_0000, 32'h1234_5678);
        w4 = mk(1'b1, 1'b0, 32'h0000_0003, 8'h1d, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001);
        w5 = mk(1'b0, 1'b0, 32'h0BAD_F00D, 8'h0a, 32'h2468_ACE0, 32'h1357_9BDF, 32'hCAFE_0000);
        w6 = mk(1'b1, 1'b1, 32'hFFFF_FFFF, 8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        w7 = mk(1'b0, 1'b0, 32'h0000_0100, 8'h16, 32'h0000_0010, 32'h0000_0020, 32'h0000_0030);

        // R2/R3: capture the status word and read it out while writing w2
        par_in = w1;
        scan(w2, 1, 1'b1, d);
        chk(d == w1, "R2", "captured word read back", d, w1);
        chk(d[31:0] == 32'hC3C3_0003, "R3", "first 32 bits out are return-stack top",
            W'(d[31:0]), W'(32'hC3C3_0003));
        chk(d[137] == 1'b1, "R3", "last bit out is halt", W'(d[137]), W'(1'b1));
        drain();
        chk(par_out == w2, "R4", "published after full shift", par_out, w2);
        chk(halt_req && step_req, "R9", "halt and step set", W'({halt_req, step_req}), W'(2'b11));

        // R3: shift-through without capture returns previous stage content
        scan(w3, 0, 1'b1, d);
        chk(d == w2, "R3", "stage shifted out unchanged", d, w2);
        drain();
        chk(!halt_req && step_req, "R9", "step only", W'({halt_req, step_req}), W'(2'b01));

        // R6: strobes while deselected have no effect
        @(negedge tck);
        tap_capture = 1'b1; tap_shift = 1'b1; tap_update = 1'b1; tdi = 1'b1;
        for (int i = 0; i < 4; i++) begin
            #1 chk(tdo == 1'b0, "R6", "tdo deselected", W'(tdo), '0);
            @(negedge tck);
        end
        tap_capture = 1'b0; tap_shift = 1'b0; tap_update = 1'b0;
        repeat (20) @(negedge clk);
        chk(par_out == w3, "R6", "output untouched while deselected", par_out, w3);
        scan(w3, 0, 1'b0, d);
        chk(d == w3, "R6", "stage untouched while deselected", d, w3);

        // R7: capture and shift on the same edge, capture wins
        par_in = w4;
        scan(w5, 2, 1'b1, d);
        chk(d == w4, "R7", "capture beats shift", d, w4);
        drain();
        chk(par_out == w5, "R4", "published after overlap scan", par_out, w5);

        // R8: tap reset clears stage only
        scan(w6, 0, 1'b0, d);
        chk(d == w5, "R3", "stage after update", d, w5);
        @(negedge tck) tap_reset = 1'b1;
        @(negedge tck) tap_reset = 1'b0;
        repeat (20) @(negedge clk);
        chk(par_out == w5, "R8", "output kept over tap reset", par_out, w5);
        scan('0, 0, 1'b0, d);
        chk(d == '0, "R8", "stage cleared by tap reset", d, '0);

        // R1: system reset mid-run, no republish afterwards
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(par_out == '0, "R1", "output cleared by reset", par_out, '0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk(par_out == '0 && !halt_req, "R1", "no republish after reset", par_out, '0);

        // R4/R9: final update clears halt and step
        scan(w7, 0, 1'b1, d);
        drain();
        chk(par_out == w7, "R4", "final word", par_out, w7);
        chk(!halt_req && !step_req, "R9", "halt and step clear", W'({halt_req, step_req}), '0);

        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule